// File: doc/BRIEF.md
# Two-Rank Nibble Latch for a 12-Bit Converter Code

This block sits between a host bus and the core of a 12-bit digital-to-analog converter. It captures the data word in three separately strobed 4-bit holding latches and then, on a fourth strobe, moves all twelve bits at once into an output latch whose contents form the converter code. The host can fill the holding latches over several writes, one or more nibbles per write, without the converter ever seeing a half-updated code.

Strobes and chip select are active low. A latch is open only while chip select and its own strobe are both low. Every latch is level-sensitive: it follows its input while open and keeps its last value once either signal goes high. When all four strobes are held low and chip select is pulsed, both ranks are open together and the input data reaches the code output directly. An active-high reset clears every latch. It takes effect at once and needs no clock.

Top module: `dac_word_latch`

## Requirements
- R1: Strobe bit 0 opens the holding latch for data bits 3:0. Strobe bit 1 opens it for bits 7:4, and strobe bit 2 opens it for bits 11:8. Each holding latch takes only its own slice of `data_i`.
- R2: While only holding-latch strobes (bits 0 to 2) are used, `code_o` does not change.
- R3: Strobe bit 3 with chip select low loads `code_o` with the word made of the high, middle and low holding latches, in that order from the top bit down.
- R4: No latch loads while `cs_n_i` is high, even with its strobe low. No latch loads while its strobe is high, even with `cs_n_i` low.
- R5: Once a latch closes, changes on `data_i` do not affect it.
- R6: Several strobes may be low in one write, and each opened latch loads its own data. This lets an 8-bit host fill the low and middle nibbles in one write and finish with the high nibble and the transfer together.
- R7: While all four strobes and `cs_n_i` are low, `code_o` follows `data_i`. It keeps the last value after `cs_n_i` goes high.
- R8: While `rst_i` is high, all four latches hold zero, so `code_o` is 0.
- R9: The output latch is fed from the holding latches and not from the data pins. A write with strobes 0 and 3 low together therefore puts the new low nibble on `code_o` and keeps the stored middle and high nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Active-high reset. Clears all latches. |
| cs_n_i | input | 1 | Active-low chip select. Qualifies every strobe. |
| strobe_n_i | input | 4 | Active-low latch strobes. Bits 0 to 2 select the low, middle and high nibbles; bit 3 selects the transfer to the output latch. |
| data_i | input | 12 | Data word. Each nibble feeds its own holding latch. |
| code_o | output | 12 | Converter code from the output latch. |

## Verification
The bench goes after four faults:
- Early leak: a design that passed holding-latch writes straight to the output would show partial codes during the nibble-by-nibble sequence.
- Wrong transfer source: a design that loaded the output latch from the data pins would put the wrong nibbles on `code_o` after a combined low-nibble-and-transfer write.
- Missing gating: designs that ignore chip select, or that use edge capture instead of level capture, would fail the checks made with chip select high.
- Broken transparency: such designs would also fail the mid-pulse checks of the fully transparent mode, where the data changes several times within one pulse.

Reset applied in mid-operation must also clear the holding latches. A design that cleared only the output would bring back old nibbles on the next transfer.

// File: rtl/dac_word_latch_pkg.sv
`timescale 1ns/1ps
package dac_word_latch_pkg;

    localparam int NIB_W_DEF   = 4;
    localparam int NIB_CNT_DEF = 3;

    // Strobe positions; the transfer strobe sits just above the nibble strobes.
    typedef enum int {
        STB_LO   = 0,
        STB_MID  = 1,
        STB_HI   = 2,
        STB_XFER = 3
    } stb_idx_e;

    // A latch is open only while chip select and its strobe are both low.
    function automatic logic latch_open(input logic cs_n, input logic stb_n);
        return (!cs_n) && (!stb_n);
    endfunction

endpackage

// File: rtl/dac_word_latch_dec.sv
`timescale 1ns/1ps
module dac_word_latch_dec
    import dac_word_latch_pkg::*;
#(
    parameter int N_STB = NIB_CNT_DEF + 1
) (
    input  logic             cs_n_i,
    input  logic [N_STB-1:0] strobe_n_i,
    output logic [N_STB-1:0] open_o
);

    for (genvar i = 0; i < N_STB; i++) begin : g_open
        assign open_o[i] = latch_open(cs_n_i, strobe_n_i[i]);
    end

endmodule

// File: rtl/dac_word_latch_cell.sv
`timescale 1ns/1ps
module dac_word_latch_cell #(
    parameter int W = 4
) (
    input  logic         rst_i,
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Level-sensitive storage: reset dominates, then transparency.
    always_latch begin
        if (rst_i) begin
            q_o <= '0;
        end else if (open_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/dac_word_latch.sv
`timescale 1ns/1ps
module dac_word_latch
    import dac_word_latch_pkg::*;
#(
    parameter int NIB_W   = NIB_W_DEF,
    parameter int NIB_CNT = NIB_CNT_DEF
) (
    input  logic                     rst_i,
    input  logic                     cs_n_i,
    input  logic [NIB_CNT:0]         strobe_n_i,
    input  logic [NIB_W*NIB_CNT-1:0] data_i,
    output logic [NIB_W*NIB_CNT-1:0] code_o
);

    localparam int WORD_W = NIB_W * NIB_CNT;
    localparam int N_STB  = NIB_CNT + 1;
    localparam int XFER   = NIB_CNT;

    logic [N_STB-1:0]  open_w;
    logic [WORD_W-1:0] nib_q;     // first-rank contents, nibble i at slice i
    logic [WORD_W-1:0] word_q;

    dac_word_latch_dec #(
        .N_STB (N_STB)
    ) dec_i (
        .cs_n_i     (cs_n_i),
        .strobe_n_i (strobe_n_i),
        .open_o     (open_w)
    );

    // First rank: one holding latch per nibble slice.
    for (genvar i = 0; i < NIB_CNT; i++) begin : g_rank1
        dac_word_latch_cell #(
            .W (NIB_W)
        ) nib_i (
            .rst_i  (rst_i),
            .open_i (open_w[i]),
            .d_i    (data_i[i*NIB_W +: NIB_W]),
            .q_o    (nib_q[i*NIB_W +: NIB_W])
        );
    end

    // Second rank: loads the assembled word from the first rank.
    dac_word_latch_cell #(
        .W (WORD_W)
    ) word_i (
        .rst_i  (rst_i),
        .open_i (open_w[XFER]),
        .d_i    (nib_q),
        .q_o    (word_q)
    );

    assign code_o = word_q;

endmodule

// File: rtl/dac_word_latch_chk.sv
`timescale 1ns/1ps
module dac_word_latch_chk #(
    parameter int NIB_W   = 4,
    parameter int NIB_CNT = 3
) (
    input logic                     rst_i,
    input logic                     cs_n_i,
    input logic [NIB_CNT:0]         strobe_n_i,
    input logic [NIB_W*NIB_CNT-1:0] data_i,
    input logic [NIB_W*NIB_CNT-1:0] code_o,
    input logic [NIB_W*NIB_CNT-1:0] nib_q
);

    // The output may move only through an open transfer latch (R2, R3).
    always @(code_o) begin
        if (rst_i == 1'b0) begin
            p_code_gated_r2: assert (!cs_n_i && !strobe_n_i[NIB_CNT])
                else $error("code changed with the transfer latch closed");
        end
    end

    // Any change while in reset must go to zero (R8).
    always @(code_o) begin
        if (rst_i == 1'b1) begin
            p_reset_zero_r8: assert (code_o == '0)
                else $error("code not zero during reset");
        end
    end

    // When chip select closes a full transparent pulse, output equals data (R7).
    always @(posedge cs_n_i) begin
        if (rst_i == 1'b0 && strobe_n_i == '0) begin
            p_transparent_r7: assert (code_o == data_i)
                else $error("transparent pulse did not reach the output");
        end
    end

    for (genvar i = 0; i < NIB_CNT; i++) begin : g_nib
        // Nibble contents move only while that nibble is open (R4).
        always @(nib_q[i*NIB_W +: NIB_W]) begin
            if (rst_i == 1'b0) begin
                p_nib_gated_r4: assert (!cs_n_i && !strobe_n_i[i])
                    else $error("nibble %0d changed while closed", i);
            end
        end
        // A nibble closing under its own strobe holds its own data slice (R1).
        always @(posedge cs_n_i) begin
            if (rst_i == 1'b0 && !strobe_n_i[i]) begin
                p_nib_capture_r1: assert (nib_q[i*NIB_W +: NIB_W] == data_i[i*NIB_W +: NIB_W])
                    else $error("nibble %0d captured the wrong slice", i);
            end
        end
    end

endmodule

bind dac_word_latch dac_word_latch_chk #(
    .NIB_W   (NIB_W),
    .NIB_CNT (NIB_CNT)
) chk_i (
    .rst_i      (rst_i),
    .cs_n_i     (cs_n_i),
    .strobe_n_i (strobe_n_i),
    .data_i     (data_i),
    .code_o     (code_o),
    .nib_q      (nib_q)
);

// File: tb/dac_word_latch_tb_top.sv
`timescale 1ns/1ps
module dac_word_latch_tb_top;

    logic        clk        = 1'b0;
    logic        rst_i      = 1'b1;
    logic        cs_n_i     = 1'b1;
    logic [3:0]  strobe_n_i = 4'hF;
    logic [11:0] data_i     = 12'h000;
    logic [11:0] code_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [11:0] code;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // Reference state derived from the requirements.
    logic [3:0]  m_nib [3];
    logic [11:0] m_code;

    always #10 clk = ~clk;

    dac_word_latch dut_i (
        .rst_i      (rst_i),
        .cs_n_i     (cs_n_i),
        .strobe_n_i (strobe_n_i),
        .data_i     (data_i),
        .code_o     (code_o)
    );

    // Monitor: compares queued expectations away from the driving edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (code_o !== e.code) begin
                bad++;
                $display("FAIL %s: code_o=%h expected %h", e.tag, code_o, e.code);
            end
        end
    end

    task automatic push(input logic [11:0] code, input string tag);
        exp_t e;
        e.code = code;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic check(input string tag);
        @(posedge clk);
        push(m_code, tag);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) m_nib[i] = 4'h0;
        m_code = 12'h000;
    endtask

    // Driver: one bus write; releases chip select first, then the strobes.
    task automatic bus_write(input logic [3:0] stb, input logic [11:0] d);
        @(posedge clk);
        data_i     = d;
        strobe_n_i = ~stb;
        cs_n_i     = 1'b0;
        for (int i = 0; i < 3; i++)
            if (stb[i]) m_nib[i] = d[i*4 +: 4];
        if (stb[3]) m_code = {m_nib[2], m_nib[1], m_nib[0]};
        @(posedge clk);
        cs_n_i = 1'b1;
        @(posedge clk);
        strobe_n_i = 4'hF;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        push(12'h000, "R8 reset state");
        @(posedge clk);
        rst_i = 1'b0;

        // Nibble-by-nibble assembly (R1, R2, R3).
        bus_write(4'b0001, 12'h3A5);
        check("R2 after low nibble");
        bus_write(4'b0010, 12'h0C0);
        check("R2 after middle nibble");
        bus_write(4'b0100, 12'h900);
        check("R2 after high nibble");
        bus_write(4'b1000, 12'h000);
        check("R3 R1 transfer 9C5");

        // Hold after release (R5).
        bus_write(4'b0001, 12'h00A);
        @(posedge clk);
        data_i = 12'hFF5;
        push(m_code, "R5 output held");
        bus_write(4'b1000, 12'hFFF);
        check("R5 low nibble held A");

        // Chip select and strobe gating (R4).
        @(posedge clk);
        strobe_n_i = 4'h0;
        cs_n_i     = 1'b1;
        data_i     = 12'h777;
        push(m_code, "R4 strobes low, chip select high");
        @(posedge clk);
        strobe_n_i = 4'hF;
        @(posedge clk);
        cs_n_i = 1'b0;
        data_i = 12'h666;
        push(m_code, "R4 chip select low, strobes high");
        @(posedge clk);
        cs_n_i = 1'b1;
        bus_write(4'b1000, 12'h000);
        check("R4 first rank untouched");

        // Eight-bit host style, several strobes per write (R6).
        bus_write(4'b0011, 12'h0B4);
        check("R2 R6 two nibbles, no transfer");
        bus_write(4'b1100, 12'h700);
        check("R6 high nibble with transfer 7B4");

        // Second rank fed from first rank (R9).
        bus_write(4'b1001, 12'hF0E);
        check("R9 low nibble plus transfer 7BE");

        // Fully transparent pulse (R7).
        @(posedge clk);
        strobe_n_i = 4'h0;
        cs_n_i     = 1'b0;
        data_i     = 12'h123;
        push(12'h123, "R7 transparent first value");
        @(posedge clk);
        data_i = 12'h456;
        push(12'h456, "R7 transparent second value");
        @(posedge clk);
        data_i = 12'hABC;
        push(12'hABC, "R7 transparent third value");
        @(posedge clk);
        cs_n_i = 1'b1;
        @(posedge clk);
        strobe_n_i = 4'hF;
        data_i     = 12'h000;
        m_nib[0] = 4'hC; m_nib[1] = 4'hB; m_nib[2] = 4'hA;
        m_code   = 12'hABC;
        push(m_code, "R7 value held after pulse");

        // Reset in mid-operation clears both ranks (R8).
        @(posedge clk);
        rst_i = 1'b1;
        model_reset();
        push(12'h000, "R8 reset clears output");
        @(posedge clk);
        rst_i = 1'b0;
        bus_write(4'b1000, 12'hFFF);
        check("R8 first rank cleared");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: finished=0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule